// File: doc/BRIEF.md
# Four-Stage In-Order Instruction Pipeline Controller

This block sequences instructions through a four-stage in-order pipeline: instruction fetch, decode together with effective-address calculation, operand fetch, and execute. It owns the program counter, drives a combinational instruction-memory read port, and moves each instruction's address and word from stage to stage with a valid bit. Arithmetic and operand forwarding belong to the surrounding datapath. The controller only decides which instruction is in which stage in every cycle.

Branches are recognised in the decode stage. The instruction fetched behind a branch is discarded, and fetch pauses until the branch has finished execute. In the following cycle the fetch stage restarts at the branch target, or at the branch address plus one when the branch is not taken. After every completing execute the controller samples an interrupt request. If one is pending, it empties the three younger stages, fetches from a fixed vector, and records the address of the first instruction that did not complete. Per-stage valid bits and addresses are brought out so that the occupancy of every stage can be compared with the expected space-time pattern.

Top module: `pipe4_ctrl`

## Requirements
- R1: While reset is held and after its release, only the fetch stage is occupied, with address RESET_PC (default 0). The decode, operand and execute stages are empty, and `irq_ack` and `retire_vld` are low.
- R2: Without branches or interrupts, a new address enters fetch every cycle, counting up by one. An instruction in fetch in cycle t is in decode in t+1, in operand fetch in t+2, and in execute (retiring on `retire_pc`) in t+3.
- R3: The opcode is word bits [AW+1:AW] and the branch target is bits [AW-1:0]. Codes 2'b00 and 2'b11 are non-branch. 2'b01 is an unconditional jump. 2'b10 is a conditional branch, taken when `br_flag` is high in the cycle the branch is in execute.
- R4: While a valid branch is in decode, the instruction in fetch is discarded, so decode is empty in the next cycle. Fetch is empty in the two cycles during which the branch is in operand fetch and execute.
- R5: In the cycle after a branch executes, fetch holds the target if the branch was taken, or the branch address plus one if not.
- R6: A discarded instruction travels as an empty slot and never appears on `retire_vld`/`retire_pc`. At most one branch is in flight among decode, operand fetch and execute.
- R7: When `irq` is high in a cycle with a valid instruction in execute, `irq_ack` is high in that cycle and that instruction retires. In the next cycle fetch holds IRQ_VEC (default 8'hF0) and decode, operand fetch and execute are empty.
- R8: On an accepted interrupt, `ret_addr` is loaded with the address following the completing instruction: its address plus one for a non-branch.
- R9: An interrupt request is not accepted while execute is empty. `irq_ack` stays low until a valid instruction reaches execute.
- R10: When an interrupt is accepted in the same cycle as a branch executes, fetch goes to IRQ_VEC, and `ret_addr` receives the branch's resolved next address (target if taken).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | AW | Instruction-memory read address (fetch-stage PC) |
| imem_rd | output | 1 | Fetch stage holds a live fetch |
| imem_data | input | AW+2 | Instruction word read combinationally at `imem_addr` |
| br_flag | input | 1 | Condition for a conditional branch in execute |
| irq | input | 1 | Level interrupt request |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| ret_addr | output | AW | Saved resume address of the last accepted interrupt |
| stg_vld | output | 4 | Stage occupancy: bit0 fetch, bit1 decode, bit2 operand, bit3 execute |
| stg_pc | output | 4*AW | Stage addresses, stage i at bits [i*AW +: AW] |
| retire_vld | output | 1 | An instruction completes execute this cycle |
| retire_pc | output | AW | Address of the completing instruction |

## Verification
A branch resolving in execute and an interrupt accepted after execute can fall in the same cycle, and both want to steer the fetch address. The bench provokes this by placing a jump at the reset address and raising `irq` in exactly the cycle the jump reaches execute. It then expects the vector in fetch, an empty pipe, and the jump target (not the jump address plus one) in `ret_addr`. A second case raises the request while the branch shadow leaves execute empty, to show that acceptance waits for the next real instruction.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

  typedef enum logic [1:0] {
    OP_ALU  = 2'b00,
    OP_JMP  = 2'b01,
    OP_BCND = 2'b10,
    OP_AUX  = 2'b11
  } opcode_e;

  function automatic logic op_is_branch(input logic [1:0] op);
    return (op == OP_JMP) || (op == OP_BCND);
  endfunction

  function automatic logic op_taken(input logic [1:0] op, input logic flag);
    return (op == OP_JMP) || ((op == OP_BCND) && flag);
  endfunction

endpackage

// File: rtl/pipe4_fetch.sv
module pipe4_fetch #(
  parameter int unsigned     AW       = 8,
  parameter logic [AW-1:0]   RESET_PC = '0,
  parameter logic [AW-1:0]   IRQ_VEC  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_irq,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_pc,
  input  logic          hold,
  output logic          fi_vld,
  output logic [AW-1:0] fi_pc
);

  logic          vld_d;
  logic [AW-1:0] pc_d;

  always_comb begin
    vld_d = 1'b1;
    pc_d  = fi_pc + AW'(1);
    if (take_irq) begin
      pc_d  = IRQ_VEC;
    end else if (redirect) begin
      pc_d  = redirect_pc;
    end else if (hold) begin
      pc_d  = fi_pc;
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_vld <= 1'b1;
      fi_pc  <= RESET_PC;
    end else begin
      fi_vld <= vld_d;
      fi_pc  <= pc_d;
    end
  end

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fi_vld && !take_irq && !redirect && !hold) |=> (fi_vld && fi_pc == $past(fi_pc) + AW'(1)));

  // R5
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !take_irq) |=> (fi_vld && fi_pc == $past(redirect_pc)));

endmodule

// File: rtl/pipe4_slot.sv
module pipe4_slot #(
  parameter int unsigned AW = 8,
  parameter int unsigned IW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_pc,
  input  logic [IW-1:0] ld_ins,
  input  logic          kill,
  output logic          q_vld,
  output logic [AW-1:0] q_pc,
  output logic [IW-1:0] q_ins
);

  logic vld_d;
  logic data_en;

  always_comb begin
    vld_d   = ld_vld && !kill;
    data_en = vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
    end else begin
      q_vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_pc  <= '0;
      q_ins <= '0;
    end else if (data_en) begin
      q_pc  <= ld_pc;
      q_ins <= ld_ins;
    end
  end

  // R7
  kill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !q_vld);

endmodule

// File: rtl/pipe4_resolve.sv
module pipe4_resolve
  import pipe4_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned IW = AW + 2
) (
  input  logic          ex_vld,
  input  logic [AW-1:0] ex_pc,
  input  logic [IW-1:0] ex_ins,
  input  logic          br_flag,
  output logic          ex_br,
  output logic [AW-1:0] ex_next
);

  logic [1:0]    op;
  logic [AW-1:0] tgt;
  logic          taken;

  always_comb begin
    op      = ex_ins[IW-1:IW-2];
    tgt     = ex_ins[AW-1:0];
    ex_br   = ex_vld && op_is_branch(op);
    taken   = op_taken(op, br_flag);
    ex_next = (ex_br && taken) ? tgt : ex_pc + AW'(1);
  end

endmodule

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl
  import pipe4_pkg::*;
#(
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] IRQ_VEC  = 8'hF0,
  localparam int unsigned  IW       = AW + 2,
  localparam int unsigned  NSLOT    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   imem_addr,
  output logic            imem_rd,
  input  logic [IW-1:0]   imem_data,
  input  logic            br_flag,
  input  logic            irq,
  output logic            irq_ack,
  output logic [AW-1:0]   ret_addr,
  output logic [3:0]      stg_vld,
  output logic [4*AW-1:0] stg_pc,
  output logic            retire_vld,
  output logic [AW-1:0]   retire_pc
);

  logic          fi_vld;
  logic [AW-1:0] fi_pc;

  logic          s_vld [NSLOT];
  logic [AW-1:0] s_pc  [NSLOT];
  logic [IW-1:0] s_ins [NSLOT];

  logic          da_br, fo_br, ex_br;
  logic          hold, redirect, take_irq;
  logic [AW-1:0] ex_next;

  always_comb begin
    da_br    = s_vld[0] && op_is_branch(s_ins[0][IW-1:IW-2]);
    fo_br    = s_vld[1] && op_is_branch(s_ins[1][IW-1:IW-2]);
    hold     = da_br || fo_br;
    redirect = ex_br;
    take_irq = s_vld[2] && irq;
  end

  pipe4_fetch #(.AW(AW), .RESET_PC(RESET_PC), .IRQ_VEC(IRQ_VEC)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_irq   (take_irq),
    .redirect   (redirect),
    .redirect_pc(ex_next),
    .hold       (hold),
    .fi_vld     (fi_vld),
    .fi_pc      (fi_pc)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic          in_vld;
    logic [AW-1:0] in_pc;
    logic [IW-1:0] in_ins;
    if (g == 0) begin : g_head
      always_comb begin
        in_vld = fi_vld && !da_br;
        in_pc  = fi_pc;
        in_ins = imem_data;
      end
    end else begin : g_body
      always_comb begin
        in_vld = s_vld[g-1];
        in_pc  = s_pc[g-1];
        in_ins = s_ins[g-1];
      end
    end
    pipe4_slot #(.AW(AW), .IW(IW)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_vld(in_vld),
      .ld_pc (in_pc),
      .ld_ins(in_ins),
      .kill  (take_irq),
      .q_vld (s_vld[g]),
      .q_pc  (s_pc[g]),
      .q_ins (s_ins[g])
    );
  end

  pipe4_resolve #(.AW(AW), .IW(IW)) u_resolve (
    .ex_vld (s_vld[2]),
    .ex_pc  (s_pc[2]),
    .ex_ins (s_ins[2]),
    .br_flag(br_flag),
    .ex_br  (ex_br),
    .ex_next(ex_next)
  );

  logic          ret_en;
  logic [AW-1:0] ret_d;

  always_comb begin
    ret_en = take_irq;
    ret_d  = ex_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_addr <= '0;
    end else if (ret_en) begin
      ret_addr <= ret_d;
    end
  end

  always_comb begin
    imem_addr  = fi_pc;
    imem_rd    = fi_vld;
    irq_ack    = take_irq;
    retire_vld = s_vld[2];
    retire_pc  = s_pc[2];
    stg_vld    = {s_vld[2], s_vld[1], s_vld[0], fi_vld};
    stg_pc     = {s_pc[2], s_pc[1], s_pc[0], fi_pc};
  end

  // R4
  br_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    da_br |=> !s_vld[0]);

  // R4
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_br || ex_br) |-> !fi_vld);

  // R6
  one_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({da_br, fo_br, ex_br}) <= 1);

  // R7
  irq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (fi_vld && fi_pc == IRQ_VEC && !s_vld[0] && !s_vld[1] && !s_vld[2]));

  // R8
  ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (ret_addr == $past(ex_next)));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !retire_vld) |-> !irq_ack);

endmodule

// File: tb/pipe4_ctrl_tb.sv
module pipe4_ctrl_tb;

  localparam int AW = 8;
  localparam int IW = AW + 2;
  localparam logic [AW-1:0] VEC = 8'hF0;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   imem_addr;
  logic            imem_rd;
  logic [IW-1:0]   imem_data;
  logic            br_flag;
  logic            irq;
  logic            irq_ack;
  logic [AW-1:0]   ret_addr;
  logic [3:0]      stg_vld;
  logic [4*AW-1:0] stg_pc;
  logic            retire_vld;
  logic [AW-1:0]   retire_pc;

  logic [IW-1:0] mem [256];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assign imem_data = mem[imem_addr];

  pipe4_ctrl #(.AW(AW), .IRQ_VEC(VEC)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_rd   (imem_rd),
    .imem_data (imem_data),
    .br_flag   (br_flag),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .ret_addr  (ret_addr),
    .stg_vld   (stg_vld),
    .stg_pc    (stg_pc),
    .retire_vld(retire_vld),
    .retire_pc (retire_pc)
  );

  function automatic int pc_of(input int s);
    return int'(stg_pc[s*AW +: AW]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic fill_nops();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    irq     = 1'b0;
    br_flag = 1'b0;
    tick(2);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    fill_nops();
    rst_n = 1'b0;
    irq = 1'b0;
    br_flag = 1'b0;
    tick(1);
    chk_eq("R1 stage occupancy in reset", int'(stg_vld), 4'b0001);
    do_reset();
    chk_eq("R1 occupancy after release", int'(stg_vld), 4'b0001);
    chk_eq("R1 fetch address", pc_of(0), 0);
    chk_eq("R1 irq_ack low", int'(irq_ack), 0);
    chk_eq("R1 retire low", int'(retire_vld), 0);
  endtask

  task automatic t_straight();
    fill_nops();
    mem[4] = {2'b11, 8'h55};
    do_reset();
    tick(3);
    chk_eq("R2 first retire valid", int'(retire_vld), 1);
    chk_eq("R2 first retire pc", int'(retire_pc), 0);
    tick(2);
    chk_eq("R2 all stages full", int'(stg_vld), 4'b1111);
    chk_eq("R2 fetch pc", pc_of(0), 5);
    chk_eq("R2 decode pc", pc_of(1), 4);
    chk_eq("R2 operand pc", pc_of(2), 3);
    chk_eq("R2 execute pc", pc_of(3), 2);
    tick(2);
    chk_eq("R3 code 11 retires as non-branch", int'(retire_pc), 4);
    chk_eq("R3 code 11 no fetch gap", int'(stg_vld), 4'b1111);
  endtask

  task automatic t_jump();
    fill_nops();
    mem[2] = {2'b01, 8'h20};
    do_reset();
    tick(3);
    chk_eq("R4 wrong-path fetch visible", int'(stg_vld), 4'b1111);
    chk_eq("R4 wrong-path fetch pc", pc_of(0), 3);
    chk_eq("R4 branch in decode", pc_of(1), 2);
    tick(1);
    chk_eq("R4 discard and fetch idle", int'(stg_vld), 4'b1100);
    tick(1);
    chk_eq("R4 fetch idle while branch executes", int'(stg_vld), 4'b1000);
    chk_eq("R4 branch retiring", int'(retire_pc), 2);
    tick(1);
    chk_eq("R5 refetch occupancy", int'(stg_vld), 4'b0001);
    chk_eq("R5 jump target fetched", pc_of(0), 8'h20);
    chk_eq("R6 no retire of discarded", int'(retire_vld), 0);
    tick(1);
    chk_eq("R6 no retire of discarded 2", int'(retire_vld), 0);
    tick(1);
    chk_eq("R6 no retire of discarded 3", int'(retire_vld), 0);
    tick(1);
    chk_eq("R6 target retires next", int'(retire_pc), 8'h20);
    chk_eq("R6 target retire valid", int'(retire_vld), 1);
  endtask

  task automatic t_cond(input bit flag);
    fill_nops();
    mem[2] = {2'b10, 8'h40};
    do_reset();
    br_flag = flag;
    tick(6);
    chk_eq(flag ? "R3 conditional taken fetch valid" : "R3 conditional not taken fetch valid",
           int'(stg_vld[0]), 1);
    chk_eq(flag ? "R5 conditional taken target" : "R5 not taken resumes at pc+1",
           pc_of(0), flag ? 8'h40 : 3);
    tick(3);
    chk_eq("R6 resumed instruction retires", int'(retire_pc), flag ? 8'h40 : 3);
    br_flag = 1'b0;
  endtask

  task automatic t_irq();
    fill_nops();
    do_reset();
    tick(4);
    irq = 1'b1;
    #1;
    chk_eq("R7 irq accepted", int'(irq_ack), 1);
    chk_eq("R7 completing instruction retires", int'(retire_pc), 1);
    tick(1);
    irq = 1'b0;
    chk_eq("R7 pipe emptied", int'(stg_vld), 4'b0001);
    chk_eq("R7 vector fetched", pc_of(0), VEC);
    chk_eq("R8 resume address", int'(ret_addr), 2);
    tick(3);
    chk_eq("R7 handler retires", int'(retire_pc), VEC);
  endtask

  task automatic t_irq_wait();
    fill_nops();
    mem[0] = {2'b01, 8'h10};
    do_reset();
    tick(4);
    irq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk_eq("R9 no accept with empty execute", int'(irq_ack), 0);
      tick(1);
    end
    #1;
    chk_eq("R9 accepted at first valid execute", int'(irq_ack), 1);
    chk_eq("R9 executing target", int'(retire_pc), 8'h10);
    tick(1);
    irq = 1'b0;
    chk_eq("R9 vector after wait", pc_of(0), VEC);
    chk_eq("R8 resume after target", int'(ret_addr), 8'h11);
  endtask

  task automatic t_collide();
    fill_nops();
    mem[0] = {2'b01, 8'h10};
    do_reset();
    tick(3);
    irq = 1'b1;
    #1;
    chk_eq("R10 accept during branch execute", int'(irq_ack), 1);
    chk_eq("R10 branch retires", int'(retire_pc), 0);
    tick(1);
    irq = 1'b0;
    chk_eq("R10 vector wins over target", pc_of(0), VEC);
    chk_eq("R10 pipe emptied", int'(stg_vld), 4'b0001);
    chk_eq("R10 resume at branch target", int'(ret_addr), 8'h10);
  endtask

  initial begin
    rst_n   = 1'b0;
    irq     = 1'b0;
    br_flag = 1'b0;
    t_reset();
    t_straight();
    t_jump();
    t_cond(1'b0);
    t_cond(1'b1);
    t_irq();
    t_irq_wait();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule